// File: doc/BRIEF.md
# Power Event Accumulator and Serializer

This block collects power-management activity reported by a processor bus and passes it to a companion chip over a three-wire serial link. Each event line has its own enable. An enabled event sets a sticky bit in an 8-bit packet register. Repeats of the same event collapse into that one bit, and different events build up together. When at least one bit is pending and a programmable interval has run out, the packet is sent. The frame is a start bit followed by the packet bits, most significant first. One bit goes out on each pulse of a divided clock.

When the last bit has been sampled, the block raises a one-cycle completion pulse. It then clears only the bits that the frame actually carried and reloads the interval counter from its configuration input. An event that arrives while a frame is shifting out is kept for the next frame. This holds even when it repeats a bit that the current frame carries, and even when it lands in the completion cycle itself.

Top module: `pwr_event_serializer`

## Requirements
- R1: After reset all outputs are low, and no frame starts while no event has been recorded.
- R2: A packet bit is set only by an event on its line while that line's enable is high. An event whose enable is low sets nothing and causes no frame.
- R3: Several events of one type between two frames produce a single set bit. That bit appears once in the next frame.
- R4: Distinct events recorded between two frames, at different times, are all carried together in the next frame.
- R5: Bit 0 of the packet is the display/graphics access event and bit 1 is the address-region hit. A frame is a start bit of value 1 followed by packet bits 7 down to 0. The receiver samples `ser_data_o` in each cycle where `ser_clk_o` is high.
- R6: With divider setting D, the first `ser_clk_o` pulse comes D cycles after `ser_frame_o` rises. Later pulses follow every D+1 cycles. `ser_frame_o` stays high for exactly 9*(D+1) cycles.
- R7: `done_o` is high for one cycle, in the first cycle after the frame ends.
- R8: A frame starts only when a bit is pending and the interval counter is zero. With reload value V and a bit pending at completion, the next frame rises V+1 cycles after `done_o`. V=0 therefore gives back-to-back frames with a one-cycle gap.
- R9: After completion the bits that were sent are cleared, so no further frame starts without new events.
- R10: An enabled event that arrives during a frame, including one in the completion cycle and one for a bit the frame carries, is sent in the following frame.
- R11: The interval reload value is sampled in the completion cycle. Later changes to `interval_i` do not affect the countdown already running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NBITS | Event pulses, one line per packet bit |
| evt_en_i | input | NBITS | Per-line event enables |
| interval_i | input | CNT_W | Interval reload value in clock cycles |
| div_i | input | DIV_W | Bit-rate divider; one bit every div_i+1 cycles |
| ser_frame_o | output | 1 | High while a frame is being sent |
| ser_clk_o | output | 1 | Bit sample pulse |
| ser_data_o | output | 1 | Serial data |
| done_o | output | 1 | One-cycle frame completion pulse |

## Verification
The packet register is written by two functions in the same clock edge: new events set bits, and frame completion clears the bits that were sent. The bench provokes this by watching for the ninth sample pulse. It drives an event for an already-sent bit so that it registers on the completion edge. A further event is held across a frame, and the same bit is re-armed mid-frame in the divider and interval sweep. In each case the result is judged only by the next frame's contents and its gap from `done_o`.

// File: rtl/pwr_event_serializer.sv
`timescale 1ns/1ps
module pwr_event_serializer #(
  parameter int NBITS = 8,
  parameter int CNT_W = 16,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] evt_i,
  input  logic [NBITS-1:0] evt_en_i,
  input  logic [CNT_W-1:0] interval_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             ser_frame_o,
  output logic             ser_clk_o,
  output logic             ser_data_o,
  output logic             done_o
);
  localparam int IDX_W = $clog2(NBITS + 1);

  logic [NBITS-1:0] pkt, sent;
  logic [NBITS:0]   shreg;
  logic [IDX_W-1:0] idx;
  logic [DIV_W-1:0] div_cnt;
  logic [CNT_W-1:0] int_cnt;
  logic             busy, done_q;

  wire [NBITS-1:0] hit  = evt_i & evt_en_i;
  wire             tick = busy && (div_cnt == '0);
  wire             last = tick && (idx == IDX_W'(NBITS));
  wire             go   = !busy && (int_cnt == '0) && (|pkt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt     <= '0;
      sent    <= '0;
      shreg   <= '0;
      idx     <= '0;
      div_cnt <= '0;
      int_cnt <= '0;
      busy    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last;
      pkt    <= (last ? (pkt & ~sent) : pkt) | hit;
      if (go) begin
        busy    <= 1'b1;
        shreg   <= {1'b1, pkt};
        sent    <= pkt & ~hit;
        idx     <= '0;
        div_cnt <= div_i;
      end else if (busy) begin
        sent <= sent & ~hit;
        if (tick) begin
          shreg   <= {shreg[NBITS-1:0], 1'b0};
          idx     <= idx + 1'b1;
          div_cnt <= div_i;
          if (last) begin
            busy    <= 1'b0;
            int_cnt <= interval_i;
          end
        end else begin
          div_cnt <= div_cnt - 1'b1;
        end
      end else if (int_cnt != '0) begin
        int_cnt <= int_cnt - 1'b1;
      end
    end
  end

  assign ser_frame_o = busy;
  assign ser_clk_o   = tick;
  assign ser_data_o  = busy & shreg[NBITS];
  assign done_o      = done_q;
endmodule

// File: rtl/pwr_event_serializer_chk.sv
`timescale 1ns/1ps
module pwr_event_serializer_chk #(
  parameter int NBITS = 8,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NBITS-1:0] evt_i,
  input logic [NBITS-1:0] evt_en_i,
  input logic [CNT_W-1:0] interval_i,
  input logic             ser_frame_o,
  input logic             ser_clk_o,
  input logic             done_o,
  input logic [NBITS-1:0] pkt,
  input logic [CNT_W-1:0] int_cnt
);
  assert_enable_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt & ~$past(pkt) & ~$past(evt_i & evt_en_i)) == '0);

  assert_sticky_until_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pkt) & ~pkt) != '0) |-> done_o);

  assert_clk_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk_o |-> ser_frame_o);

  assert_done_after_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!ser_frame_o && $past(ser_frame_o)));

  assert_start_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_frame_o) |-> ($past(int_cnt) == '0 && $past(pkt) != '0));

  assert_reload_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (int_cnt == $past(interval_i)));
endmodule

bind pwr_event_serializer pwr_event_serializer_chk #(.NBITS(NBITS), .CNT_W(CNT_W)) chk_i (.*);

// File: tb/pwr_event_serializer_test.sv
`timescale 1ns/1ps
module pwr_event_serializer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt = '0, en = '0;
  logic [15:0] interval = '0;
  logic [7:0] div = '0;
  logic       ser_frame_o, ser_clk_o, ser_data_o, done_o;

  pwr_event_serializer uut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .evt_en_i(en),
    .interval_i(interval), .div_i(div),
    .ser_frame_o(ser_frame_o), .ser_clk_o(ser_clk_o),
    .ser_data_o(ser_data_o), .done_o(done_o));

  always #4 clk = ~clk;

  int cyc = 0, total = 0, fails = 0;
  int rise_cyc = 0, done_cyc = 0, gap = 0, frame_len = 0, nb = 0;
  int frames = 0, tim_err = 0, start_err = 0;
  logic [7:0] rx = '0, last_byte = '0;
  logic prev_frame = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ser_frame_o && !prev_frame) begin
        rise_cyc = cyc; nb = 0; rx = '0; gap = cyc - done_cyc;
      end
      if (ser_clk_o) begin
        if (cyc != rise_cyc + int'(div) + nb * (int'(div) + 1)) tim_err++;
        if (nb == 0) begin
          if (!ser_data_o) start_err++;
        end else rx = {rx[6:0], ser_data_o};
        nb++;
      end
      if (done_o) begin
        last_byte = rx; frame_len = cyc - rise_cyc; done_cyc = cyc; frames++;
      end
    end
    prev_frame = ser_frame_o;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input logic [7:0] m);
    @(negedge clk) evt = m;
    @(negedge clk) evt = '0;
  endtask

  task automatic wait_frames(input int target);
    while (frames < target) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_rise();
    while (!ser_frame_o) @(negedge clk);
  endtask

  initial begin
    while (cyc < 150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int f0;
    logic [7:0] a, b;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check({ser_frame_o, ser_clk_o, ser_data_o, done_o} == 4'b0, "R1 reset outputs",
          {ser_frame_o, ser_clk_o, ser_data_o, done_o}, 0);
    en = 8'hFF;
    idle(20);
    check(frames == 0 && !ser_frame_o, "R1 no frame without events", frames, 0);

    en = 8'h0F;
    pulse(8'hF0);
    idle(40);
    check(frames == 0, "R2 disabled events ignored", frames, 0);

    for (int d = 0; d < 4; d++) begin
      for (int v = 0; v < 4; v++) begin
        int k;
        k = d * 4 + v;
        @(negedge clk);
        div = 8'(d); interval = 16'(v);
        en = 8'hFF ^ (8'h01 << ((k + 3) % 8));
        a = (8'h01 << (k % 8)) | 8'h80 | (8'h01 << ((k + 3) % 8));
        b = 8'h01 << ((k + 5) % 8);
        f0 = frames;
        pulse(a);
        wait_rise();
        evt = b; idle(3); evt = '0;
        wait_frames(f0 + 1);
        check(last_byte == (a & en), "R2 R5 masked packet", last_byte, a & en);
        check(frame_len == 9 * (d + 1), "R6 frame length", frame_len, 9 * (d + 1));
        wait_frames(f0 + 2);
        check(last_byte == b, "R3 R10 repeated mid-frame event", last_byte, b);
        check(gap == v + 1, "R8 interval gap", gap, v + 1);
        idle(40);
        check(frames == f0 + 2, "R9 sent bits cleared", frames, f0 + 2);
      end
    end
    check(tim_err == 0, "R6 bit spacing", tim_err, 0);
    check(start_err == 0, "R5 start bit", start_err, 0);

    @(negedge clk);
    div = 8'd1; interval = 16'd30; en = 8'hFF;
    f0 = frames;
    pulse(8'h40);
    wait_frames(f0 + 1);
    idle(5);
    pulse(8'h01);
    idle(6);
    pulse(8'h02);
    wait_frames(f0 + 2);
    check(last_byte == 8'h03, "R4 R5 accumulated display and region bits", last_byte, 8'h03);

    @(negedge clk);
    interval = 16'd0;
    f0 = frames;
    pulse(8'h10);
    begin
      int n;
      n = 0;
      while (n < 9) begin
        @(negedge clk);
        if (ser_clk_o) n++;
      end
      evt = 8'h10;
      @(negedge clk) evt = '0;
    end
    wait_frames(f0 + 2);
    check(last_byte == 8'h10, "R10 event in completion cycle", last_byte, 8'h10);
    check(gap == 1, "R8 zero interval back to back", gap, 1);

    idle(10);
    interval = 16'd5;
    f0 = frames;
    pulse(8'h20);
    wait_rise();
    pulse(8'h04);
    while (!done_o) @(negedge clk);
    interval = 16'd20;
    wait_frames(f0 + 2);
    check(gap == 6, "R11 reload sampled at completion", gap, 6);
    check(last_byte == 8'h04, "R10 event during frame held", last_byte, 8'h04);

    idle(5);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule